// File: doc/BRIEF.md
# Word-Granular Configuration Access Sequencer

This block sits between a host that asks for byte, halfword or word configuration reads and writes and a bridge back end that can only move whole 32-bit words. Every back-end access is two register transfers. The first writes a configuration address to an address register. The second reads or writes a data register. The block builds that address from the bus number, device/function number and register offset. From the bus number it chooses between a local (Type 0) and a forwarded (Type 1) cycle. Targets outside the supported range are refused without touching the back end.

Narrow reads fetch the full word and hand back the addressed lane, counting lanes from the most significant end. Narrow writes fetch the full word, patch the addressed lane and write the word back. For the whole of each back-end access the block pulls a chip-select steering output low. It raises the output again once the result is ready.

Requests enter on a valid/ready channel. `req_ready` is high only while the block is idle, so a request waits in place until it is taken. Results leave on a valid/ready channel. Once `rsp_valid` rises, the status and data hold steady until `rsp_ready` is seen high on a clock edge. No new request is taken until then.

Top module: `wordcfg_seq`

## Requirements
- R1: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when the block is idle, and it stays low from acceptance until the response handshake completes.
- R2: A request with bus number above 7 or device/function above 127 makes no back-end transfer. It is answered with status 2'b01 (no device), data zero, and `cs_sel` staying high.
- R3: The word written to the address register (offset 0x500) is {8'h00, bus, devfn, offset[7:2], 1'b0, t}. Bus sits in bits 23:16, devfn in bits 15:8, and the offset's two low bits are dropped.
- R4: t (bit 0 of the address word) is 0 when the bus number is 0 and 1 for any other bus number.
- R5: A read makes two transfers: an address-register write, then a data-register read (offset 0x504). A word write (size 2'b10) makes two transfers: an address-register write, then a data-register write carrying `req_wdata`. A word read returns the fetched word with status 2'b00.
- R6: A byte read (size 2'b00) returns byte number offset[1:0] counted from the most significant byte (0 means bits 31:24), zero-extended.
- R7: A halfword read (size 2'b01) returns halfword number offset[1] counted from the most significant half (0 means bits 31:16), zero-extended.
- R8: A byte or halfword write makes four transfers in this order: address write, data read, address write, data write. The written word equals the fetched word with only the addressed lane replaced, and the new lane value comes from the low bits of `req_wdata`.
- R9: `cs_sel` is high while idle and low on every cycle in which `be_req` is high. It is high again while the response is offered.
- R10: When `be_err` comes with a data-register read, the status is 2'b10 and the data is all ones. A narrow write whose fetch fails makes no further transfer.
- R11: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_status` and `rsp_data` hold their values.
- R12: While `be_req` is high without `be_ack`, `be_req`, `be_we`, `be_addr` and `be_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken (idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Target device/function |
| req_offset | input | 8 | Register offset |
| req_wdata | input | 32 | Write data (narrow data in low bits) |
| rsp_valid | output | 1 | Result offered |
| rsp_ready | input | 1 | Result taken |
| rsp_status | output | 2 | 00 ok, 01 no device, 10 back-end error |
| rsp_data | output | 32 | Read result, zero for writes |
| be_req | output | 1 | Back-end transfer request |
| be_we | output | 1 | Back-end transfer is a write |
| be_addr | output | 12 | Back-end register offset |
| be_wdata | output | 32 | Back-end write data |
| be_ack | input | 1 | Back-end transfer complete |
| be_err | input | 1 | Back-end timeout or no response, valid with ack |
| be_rdata | input | 32 | Back-end read data, valid with ack |
| cs_sel | output | 1 | Chip-select steering, low during an access |

## Verification
The properties assume that the back end raises `be_ack` only while `be_req` is high, as a single-cycle pulse, with `be_err` and `be_rdata` meaningful only alongside it. They also assume that request fields are steady while `req_valid` is high. The bench's back-end model waits a programmable number of cycles before a one-cycle acknowledge, and it returns data from a small register file selected by the last address written. Its request tasks hold every field from the falling edge where `req_valid` rises until acceptance. The response side is stalled for several cycles in one scenario so the hold rule is exercised.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;

  typedef enum logic [1:0] {
    STS_OK     = 2'b00,
    STS_NODEV  = 2'b01,
    STS_BUSERR = 2'b10
  } status_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_FETCH,
    PH_READDR,
    PH_STORE,
    PH_RESP
  } phase_e;

  typedef struct packed {
    logic       write;
    logic [1:0] size;
    logic [7:0] bus;
    logic [7:0] devfn;
    logic [7:0] offset;
    logic [31:0] wdata;
  } cmd_t;

endpackage

// File: rtl/cfgseq_addr_fmt.sv
module cfgseq_addr_fmt #(
  parameter int DW        = 32,
  parameter int MAX_BUS   = 7,
  parameter int MAX_DEVFN = 127
) (
  input  logic [7:0]    bus,
  input  logic [7:0]    devfn,
  input  logic [7:0]    offset,
  output logic [DW-1:0] cfg_word,
  output logic          in_range
);
  localparam int PAD = DW - 24;

  logic fwd;

  // Any nonzero bus is beyond the local segment: forwarded format.
  assign fwd      = (bus != 8'd0);
  assign cfg_word = {{PAD{1'b0}}, bus, devfn, offset[7:2], 1'b0, fwd};
  assign in_range = (int'(bus) <= MAX_BUS) && (int'(devfn) <= MAX_DEVFN);

endmodule

// File: rtl/cfgseq_lane.sv
module cfgseq_lane
  import cfgseq_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] cur_word,
  input  logic [DW-1:0] new_val,
  input  logic [1:0]    size,
  input  logic [1:0]    lane,
  output logic [DW-1:0] rd_val,
  output logic [DW-1:0] merged
);
  localparam int NB = DW / 8;
  localparam int NH = NB / 2;

  logic [DW-1:0] sh_b;
  logic [DW-1:0] sh_h;

  // Lanes count from the most significant end.
  always_comb begin
    sh_b = cur_word >> (8 * (NB - 1 - int'(lane)));
    sh_h = cur_word >> (16 * (NH - 1 - int'(lane[1])));
    case (size)
      SZ_BYTE: rd_val = DW'(sh_b[7:0]);
      SZ_HALF: rd_val = DW'(sh_h[15:0]);
      default: rd_val = cur_word;
    endcase
  end

  for (genvar g = 0; g < NB; g++) begin : g_byte
    localparam int HI = DW - 1 - 8 * g;
    logic       pick;
    logic [7:0] nb;
    always_comb begin
      case (size)
        SZ_BYTE: begin
          pick = (lane == 2'(g));
          nb   = new_val[7:0];
        end
        SZ_HALF: begin
          pick = (lane[1] == 1'(g / 2));
          nb   = ((g % 2) == 0) ? new_val[15:8] : new_val[7:0];
        end
        default: begin
          pick = 1'b1;
          nb   = new_val[HI -: 8];
        end
      endcase
    end
    assign merged[HI -: 8] = pick ? nb : cur_word[HI -: 8];
  end

endmodule

// File: rtl/cfgseq_ctrl.sv
module cfgseq_ctrl
  import cfgseq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   take,
  input  logic   in_range,
  input  logic   cmd_write,
  input  logic   cmd_word,
  input  logic   be_ack,
  input  logic   be_err,
  input  logic   rsp_ready,
  output phase_e phase,
  output logic   idle,
  output logic   xfer_on,
  output logic   addr_phase,
  output logic   xfer_we,
  output logic   cs_sel
);
  phase_e nxt;

  always_comb begin
    nxt = phase;
    case (phase)
      PH_IDLE:   if (take) nxt = in_range ? PH_ADDR : PH_RESP;
      PH_ADDR:   if (be_ack) begin
                   if (be_err)                    nxt = PH_RESP;
                   else if (cmd_write && cmd_word) nxt = PH_STORE;
                   else                           nxt = PH_FETCH;
                 end
      PH_FETCH:  if (be_ack) nxt = (cmd_write && !be_err) ? PH_READDR : PH_RESP;
      PH_READDR: if (be_ack) nxt = be_err ? PH_RESP : PH_STORE;
      PH_STORE:  if (be_ack) nxt = PH_RESP;
      PH_RESP:   if (rsp_ready) nxt = PH_IDLE;
      default:   nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      cs_sel <= 1'b1;
    end else begin
      phase  <= nxt;
      cs_sel <= (nxt == PH_IDLE) || (nxt == PH_RESP);
    end
  end

  assign idle       = (phase == PH_IDLE);
  assign addr_phase = (phase == PH_ADDR) || (phase == PH_READDR);
  assign xfer_on    = addr_phase || (phase == PH_FETCH) || (phase == PH_STORE);
  assign xfer_we    = (phase != PH_FETCH);

endmodule

// File: rtl/wordcfg_seq.sv
module wordcfg_seq
  import cfgseq_pkg::*;
#(
  parameter int          DW           = 32,
  parameter int          BE_AW        = 12,
  parameter logic [11:0] ADDR_REG_OFS = 12'h500,
  parameter logic [11:0] DATA_REG_OFS = 12'h504,
  parameter int          MAX_BUS      = 7,
  parameter int          MAX_DEVFN    = 127
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [1:0]       req_size,
  input  logic [7:0]       req_bus,
  input  logic [7:0]       req_devfn,
  input  logic [7:0]       req_offset,
  input  logic [DW-1:0]    req_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [1:0]       rsp_status,
  output logic [DW-1:0]    rsp_data,
  output logic             be_req,
  output logic             be_we,
  output logic [BE_AW-1:0] be_addr,
  output logic [DW-1:0]    be_wdata,
  input  logic             be_ack,
  input  logic             be_err,
  input  logic [DW-1:0]    be_rdata,
  output logic             cs_sel
);
  cmd_t          cmd_q;
  phase_e        phase;
  logic          idle, xfer_on, addr_phase, xfer_we;
  logic          take, in_range_now;
  logic [DW-1:0] cfg_word, fetched_q, lane_rd, lane_merged;
  logic [DW-1:0] fetch_view;
  logic [1:0]    status_q;
  logic [DW-1:0] data_q;
  logic          cmd_word;

  assign take     = req_valid && req_ready;
  assign cmd_word = !(cmd_q.size == SZ_BYTE || cmd_q.size == SZ_HALF);

  // Address format and range decision on the live request fields
  cfgseq_addr_fmt #(.DW(DW), .MAX_BUS(MAX_BUS), .MAX_DEVFN(MAX_DEVFN)) u_chk_rng (
    .bus      (req_bus),
    .devfn    (req_devfn),
    .offset   (req_offset),
    .cfg_word (),
    .in_range (in_range_now)
  );

  // Address format on the held command
  cfgseq_addr_fmt #(.DW(DW), .MAX_BUS(MAX_BUS), .MAX_DEVFN(MAX_DEVFN)) u_fmt (
    .bus      (cmd_q.bus),
    .devfn    (cmd_q.devfn),
    .offset   (cmd_q.offset),
    .cfg_word (cfg_word),
    .in_range ()
  );

  cfgseq_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .in_range   (in_range_now),
    .cmd_write  (cmd_q.write),
    .cmd_word   (cmd_word),
    .be_ack     (be_ack),
    .be_err     (be_err),
    .rsp_ready  (rsp_ready),
    .phase      (phase),
    .idle       (idle),
    .xfer_on    (xfer_on),
    .addr_phase (addr_phase),
    .xfer_we    (xfer_we),
    .cs_sel     (cs_sel)
  );

  // Lane view of the word on the back-end data bus during a fetch,
  // merge against the word kept from that fetch.
  assign fetch_view = (phase == PH_FETCH) ? be_rdata : fetched_q;

  cfgseq_lane #(.DW(DW)) u_lane (
    .cur_word (fetch_view),
    .new_val  (cmd_q.wdata),
    .size     (cmd_q.size),
    .lane     (cmd_q.offset[1:0]),
    .rd_val   (lane_rd),
    .merged   (lane_merged)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      fetched_q <= '0;
      status_q  <= STS_OK;
      data_q    <= '0;
    end else begin
      if (take) begin
        cmd_q.write  <= req_write;
        cmd_q.size   <= req_size;
        cmd_q.bus    <= req_bus;
        cmd_q.devfn  <= req_devfn;
        cmd_q.offset <= req_offset;
        cmd_q.wdata  <= req_wdata;
        data_q       <= '0;
        status_q     <= in_range_now ? STS_OK : STS_NODEV;
      end
      if (xfer_on && be_ack) begin
        if (be_err) begin
          status_q <= STS_BUSERR;
          data_q   <= (phase == PH_FETCH) ? {DW{1'b1}} : '0;
        end else if (phase == PH_FETCH) begin
          fetched_q <= be_rdata;
          data_q    <= cmd_q.write ? '0 : lane_rd;
        end
      end
    end
  end

  assign req_ready  = idle;
  assign rsp_valid  = (phase == PH_RESP);
  assign rsp_status = status_q;
  assign rsp_data   = data_q;

  assign be_req   = xfer_on;
  assign be_we    = xfer_we;
  assign be_addr  = BE_AW'(addr_phase ? ADDR_REG_OFS : DATA_REG_OFS);
  assign be_wdata = addr_phase ? cfg_word
                  : (phase == PH_STORE ? (cmd_word ? cmd_q.wdata : lane_merged) : '0);

endmodule

// File: rtl/wordcfg_seq_chk.sv
module wordcfg_seq_chk #(
  parameter int          DW           = 32,
  parameter int          BE_AW        = 12,
  parameter logic [11:0] ADDR_REG_OFS = 12'h500,
  parameter int          MAX_BUS      = 7,
  parameter int          MAX_DEVFN    = 127
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [7:0]       req_bus,
  input logic [7:0]       req_devfn,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [1:0]       rsp_status,
  input logic [DW-1:0]    rsp_data,
  input logic             be_req,
  input logic             be_we,
  input logic [BE_AW-1:0] be_addr,
  input logic [DW-1:0]    be_wdata,
  input logic             be_ack,
  input logic             cs_sel
);
  // R9
  cs_low_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    be_req |-> !cs_sel);

  // R12
  be_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    be_req && !be_ack |=> be_req && $stable(be_we) && $stable(be_addr) && $stable(be_wdata));

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_status) && $stable(rsp_data));

  // R2
  reject_no_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (int'(req_bus) > MAX_BUS || int'(req_devfn) > MAX_DEVFN)
    |=> !be_req && rsp_valid && rsp_status == 2'b01);

  // R1
  one_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || be_req) |-> !req_ready);

  // R3
  addr_word_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    be_req && be_addr == BE_AW'(ADDR_REG_OFS) |-> be_we && be_wdata[1] == 1'b0 && be_wdata[DW-1:24] == '0);

endmodule

bind wordcfg_seq wordcfg_seq_chk #(
  .DW(DW), .BE_AW(BE_AW), .ADDR_REG_OFS(ADDR_REG_OFS), .MAX_BUS(MAX_BUS), .MAX_DEVFN(MAX_DEVFN)
) u_seq_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_bus    (req_bus),
  .req_devfn  (req_devfn),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_status (rsp_status),
  .rsp_data   (rsp_data),
  .be_req     (be_req),
  .be_we      (be_we),
  .be_addr    (be_addr),
  .be_wdata   (be_wdata),
  .be_ack     (be_ack),
  .cs_sel     (cs_sel)
);

// File: tb/wordcfg_seq_tb_top.sv
module wordcfg_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b0;
  logic [1:0]  req_size = 2'b10;
  logic [7:0]  req_bus = '0, req_devfn = '0, req_offset = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, be_req, be_we, cs_sel;
  logic [1:0]  rsp_status;
  logic [31:0] rsp_data, be_wdata;
  logic [11:0] be_addr;
  logic        be_ack, be_err;
  logic [31:0] be_rdata;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  wordcfg_seq dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_bus(req_bus), .req_devfn(req_devfn),
    .req_offset(req_offset), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
    .rsp_data(rsp_data),
    .be_req(be_req), .be_we(be_we), .be_addr(be_addr), .be_wdata(be_wdata),
    .be_ack(be_ack), .be_err(be_err), .be_rdata(be_rdata), .cs_sel(cs_sel)
  );

  // ---------------- back-end model ----------------
  function automatic logic [31:0] seed(int i);
    return {8'(i), 8'hA5, 8'(i) ^ 8'h3C, 8'hC3};
  endfunction

  int          lat = 0;
  int          cnt;
  int          nlog;
  int          cs_bad;
  logic [31:0] areg;
  logic [31:0] mem [64];
  logic [11:0] log_addr [256];
  logic        log_we   [256];
  logic [31:0] log_data [256];

  always @(posedge clk) begin
    if (!rst_n) begin
      be_ack <= 1'b0; be_err <= 1'b0; be_rdata <= '0;
      cnt <= 0; nlog <= 0; cs_bad <= 0; areg <= '0;
      for (int i = 0; i < 64; i++) mem[i] <= seed(i);
    end else begin
      if (be_req && be_ack) begin
        log_addr[nlog[7:0]] <= be_addr;
        log_we[nlog[7:0]]   <= be_we;
        log_data[nlog[7:0]] <= be_wdata;
        nlog <= nlog + 1;
        if (cs_sel) cs_bad <= cs_bad + 1;
        if (be_we) begin
          if (be_addr == 12'h500) areg <= be_wdata;
          else if (!be_err) mem[areg[7:2]] <= be_wdata;
        end
      end
      if (be_ack) begin
        be_ack <= 1'b0; be_err <= 1'b0;
      end else if (be_req) begin
        if (cnt >= lat) begin
          be_ack   <= 1'b1;
          cnt      <= 0;
          be_rdata <= mem[areg[7:2]];
          be_err   <= !be_we && be_addr == 12'h504 && areg[15:8] == 8'h7F;
        end else cnt <= cnt + 1;
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check32(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  logic [1:0]  got_sts;
  logic [31:0] got_dat;
  int          base_n, n_xfer;

  task automatic do_req(logic wr, logic [1:0] sz, logic [7:0] b, logic [7:0] df,
                        logic [7:0] ofs, logic [31:0] wd, int hold);
    @(negedge clk);
    base_n = nlog;
    req_valid = 1'b1; req_write = wr; req_size = sz; req_bus = b;
    req_devfn = df; req_offset = ofs; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check32("R1 ready low after accept", 32'(req_ready), 32'd0);
    while (!rsp_valid) @(negedge clk);
    got_sts = rsp_status; got_dat = rsp_data;
    check32("R9 cs high with response", 32'(cs_sel), 32'd1);
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check32("R11 valid held", 32'(rsp_valid), 32'd1);
      check32("R11 data held", rsp_data, got_dat);
      check32("R11 status held", 32'(rsp_status), 32'(got_sts));
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    n_xfer = nlog - base_n;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check32("R9 cs high at reset", 32'(cs_sel), 32'd1);
    check32("R1 ready at reset", 32'(req_ready), 32'd1);
    check32("R11 no response at reset", 32'(rsp_valid), 32'd0);
    check32("R12 no transfer at reset", 32'(be_req), 32'd0);
  endtask

  task automatic t_reject();
    do_req(1'b0, 2'b10, 8'd8, 8'h10, 8'h00, '0, 0);
    check32("R2 bus>7 status", 32'(got_sts), 32'd1);
    check32("R2 bus>7 data", got_dat, 32'd0);
    check32("R2 bus>7 transfers", 32'(n_xfer), 32'd0);
    do_req(1'b1, 2'b10, 8'd0, 8'h80, 8'h38, 32'h0BAD_0BAD, 0);
    check32("R2 devfn>127 status", 32'(got_sts), 32'd1);
    check32("R2 devfn>127 transfers", 32'(n_xfer), 32'd0);
    check32("R2 devfn>127 no write", mem[14], seed(14));
  endtask

  task automatic t_word_read_local();
    do_req(1'b0, 2'b10, 8'd0, 8'h18, 8'h0B, '0, 0);
    check32("R5 read transfer count", 32'(n_xfer), 32'd2);
    check32("R3 address word", log_data[base_n[7:0]], 32'h0000_1808);
    check32("R5 first to address reg", {19'd0, log_we[base_n[7:0]], log_addr[base_n[7:0]]}, 32'h1500);
    check32("R5 then data reg read", {19'd0, log_we[8'(base_n + 1)], log_addr[8'(base_n + 1)]}, 32'h0504);
    check32("R5 word data", got_dat, seed(2));
    check32("R5 status ok", 32'(got_sts), 32'd0);
  endtask

  task automatic t_byte_read_fwd();
    logic [31:0] w;
    w = seed(4);
    do_req(1'b0, 2'b00, 8'd5, 8'h21, 8'h13, '0, 0);
    check32("R4 forwarded address word", log_data[base_n[7:0]], 32'h0005_2111);
    check32("R6 byte lane 3", got_dat, {24'd0, w[7:0]});
    do_req(1'b0, 2'b00, 8'd0, 8'h21, 8'h10, '0, 0);
    check32("R4 local address word", log_data[base_n[7:0]], 32'h0000_2110);
    check32("R6 byte lane 0", got_dat, {24'd0, w[31:24]});
    do_req(1'b0, 2'b00, 8'd0, 8'h21, 8'h11, '0, 0);
    check32("R6 byte lane 1", got_dat, {24'd0, w[23:16]});
  endtask

  task automatic t_half_read();
    logic [31:0] w;
    w = seed(5);
    do_req(1'b0, 2'b01, 8'd0, 8'h08, 8'h16, '0, 0);
    check32("R7 half 1", got_dat, {16'd0, w[15:0]});
    do_req(1'b0, 2'b01, 8'd0, 8'h08, 8'h14, '0, 0);
    check32("R7 half 0", got_dat, {16'd0, w[31:16]});
  endtask

  task automatic t_narrow_write();
    logic [31:0] w;
    w = seed(8);
    do_req(1'b1, 2'b00, 8'd0, 8'h30, 8'h21, 32'hDEAD_BE77, 0);
    check32("R8 byte write transfers", 32'(n_xfer), 32'd4);
    check32("R8 order 0", {19'd0, log_we[base_n[7:0]], log_addr[base_n[7:0]]}, 32'h1500);
    check32("R8 order 1", {19'd0, log_we[8'(base_n + 1)], log_addr[8'(base_n + 1)]}, 32'h0504);
    check32("R8 order 2", {19'd0, log_we[8'(base_n + 2)], log_addr[8'(base_n + 2)]}, 32'h1500);
    check32("R8 order 3", {19'd0, log_we[8'(base_n + 3)], log_addr[8'(base_n + 3)]}, 32'h1504);
    check32("R8 byte merged", mem[8], {w[31:24], 8'h77, w[15:0]});
    check32("R8 write data zero", got_dat, 32'd0);
    w = seed(9);
    do_req(1'b1, 2'b01, 8'd0, 8'h30, 8'h26, 32'h1234_ABCD, 0);
    check32("R8 half write transfers", 32'(n_xfer), 32'd4);
    check32("R8 half merged", mem[9], {w[31:16], 16'hABCD});
  endtask

  task automatic t_word_write();
    do_req(1'b1, 2'b10, 8'd0, 8'h30, 8'h2C, 32'hCAFE_F00D, 0);
    check32("R5 word write transfers", 32'(n_xfer), 32'd2);
    check32("R5 word write stored", mem[11], 32'hCAFE_F00D);
    check32("R5 word write status", 32'(got_sts), 32'd0);
  endtask

  task automatic t_error();
    do_req(1'b0, 2'b10, 8'd0, 8'h7F, 8'h30, '0, 0);
    check32("R10 error status", 32'(got_sts), 32'd2);
    check32("R10 error data", got_dat, 32'hFFFF_FFFF);
    do_req(1'b1, 2'b00, 8'd0, 8'h7F, 8'h34, 32'h0000_0055, 0);
    check32("R10 aborted write transfers", 32'(n_xfer), 32'd2);
    check32("R10 aborted write status", 32'(got_sts), 32'd2);
    check32("R10 no store", mem[13], seed(13));
  endtask

  task automatic t_stall();
    lat = 3;
    do_req(1'b0, 2'b00, 8'd2, 8'h40, 8'h1A, '0, 5);
    check32("R12 slow back-end byte read", got_dat, {24'd0, seed(6) >> 8 & 32'hFF});
    check32("R9 cs low at every transfer", 32'(cs_bad), 32'd0);
    lat = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reject();
    t_word_read_local();
    t_byte_read_fwd();
    t_half_read();
    t_narrow_write();
    t_word_write();
    t_error();
    t_stall();
    summary();
    $finish;
  end

endmodule